// File: doc/BRIEF.md
# I2C Bit-Level Line Sequencer

This block is the lowest layer of an I2C master. It owns the open-drain clock and data lines and turns one command at a time into a fixed series of line states. The commands are start, repeated start, stop, write byte (with an acknowledge check), read byte, and send one acknowledge bit. A higher layer handles byte counts, addressing, retries and error policy. It issues commands over a valid/ready handshake and reads back the last received byte and the last sampled acknowledge level.

Each line state is held for a whole number of system-clock ticks. That number is picked, per command, from a speed class: 10 ticks for standard rate, 3 for fast rate and 1 for fast-plus rate. Data reception and acknowledge sampling always clock with data released. The SDA input passes through a two-flop synchronizer before it is sampled.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: The speed class in `cmd_speed` gives a hold of N ticks per step: 0 gives N=10, 1 gives N=3, 2 or 3 gives N=1. After an accepted command, `cmd_ready` stays low for exactly S*N cycles and then returns high. S is 3 for start, 4 for repeated start, 3 for stop, 27 for write, 17 for read and 3 for send-bit. The first step appears on the lines in the cycle after acceptance.
- R2: Line outputs are open-drain enables: `scl_oe`/`sda_oe` = 1 pulls the line low, and the line level is the inverse of the enable. After reset both lines are released, `cmd_ready` is 1, `rsp_rdata` is 0 and `rsp_ackbit` is 1.
- R3: Start (`cmd_op`=0) steps the lines as (SCL,SDA) = (1,1), (1,0), (0,0).
- R4: Repeated start (`cmd_op`=1) steps the lines as (0,1), (1,1), (1,0), (0,0).
- R5: Stop (`cmd_op`=2) steps the lines as (0,0), (1,0), (1,1).
- R6: Write (`cmd_op`=3) sends `cmd_wdata` most significant bit first, each bit d as (0,d), (1,d), (0,d). It then runs an acknowledge pulse (0,1), (1,1), (0,1). `rsp_ackbit` takes the synchronized SDA level sampled at the end of that high step (0 = acknowledged), and `rsp_rdata` is unchanged.
- R7: Read (`cmd_op`=4) steps (0,1) and then eight pulses of (1,1), (0,1), with SDA never pulled. At the end of each high step SDA is shifted in as byte = byte*2 + SDA. `rsp_rdata` holds the byte when the command ends, and `rsp_ackbit` is unchanged.
- R8: Send-bit (`cmd_op`=5) sends d = `cmd_wdata[0]` as (0,d), (1,d), (0,d). 0 acknowledges and 1 does not. Both response outputs are unchanged.
- R9: Codes 6 and 7 of `cmd_op` are consumed with no effect: the lines do not move, `cmd_ready` stays high and the responses are unchanged.
- R10: Operation, data and speed class are captured at acceptance. Changing those inputs while a command runs does not alter its line sequence or its duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; a valid command is taken on this edge |
| cmd_op | input | 3 | Command code (0 start, 1 repeated start, 2 stop, 3 write, 4 read, 5 send-bit) |
| cmd_wdata | input | 8 | Byte to write; bit 0 is the send-bit value |
| cmd_speed | input | 2 | Speed class selecting the per-step hold |
| rsp_rdata | output | 8 | Last received byte |
| rsp_ackbit | output | 1 | Last sampled acknowledge level (0 = acknowledged) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level, asynchronous |

## Verification
A wrong step position or data bit shows up at once as a wrong (SCL,SDA) pair. The bench samples the lines once per step, at the start of each hold window, so the fault is caught in the same step. A wrong hold count or stale captured speed class moves every later step by whole ticks and changes the ready-low length, so it is caught within one step of the error. Faults in the shift register or the sample point only reach `rsp_rdata` or `rsp_ackbit` when the command ends. They are compared there against bytes the slave model drove bit by bit.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4,
        OP_SENDBIT = 3'd5
    } op_e;

    typedef struct packed {
        logic [1:0] phase;
        logic [3:0] bitn;
    } pos_t;

    localparam int unsigned BYTE_BITS = 8;

    function automatic logic op_legal(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic is_data_op(input op_e op);
        return (op == OP_WRITE) || (op == OP_READ) || (op == OP_SENDBIT);
    endfunction

    // Position of the step that follows (phase, bitn) for a given command.
    function automatic pos_t step_next(input op_e op, input logic [1:0] phase,
                                       input logic [3:0] bitn);
        pos_t p;
        p.phase = phase + 2'd1;
        p.bitn  = bitn;
        if (op == OP_WRITE && phase == 2'd2) begin
            p.phase = 2'd0;
            p.bitn  = bitn + 4'd1;
        end else if (op == OP_READ && phase == 2'd2) begin
            p.phase = 2'd1;
            p.bitn  = bitn + 4'd1;
        end
        return p;
    endfunction

    function automatic logic step_is_last(input op_e op, input logic [1:0] phase,
                                          input logic [3:0] bitn);
        logic r;
        case (op)
            OP_START, OP_STOP, OP_SENDBIT: r = (phase == 2'd2);
            OP_RSTART:                     r = (phase == 2'd3);
            OP_WRITE:                      r = (bitn == 4'(BYTE_BITS)) && (phase == 2'd2);
            OP_READ:                       r = (bitn == 4'(BYTE_BITS - 1)) && (phase == 2'd2);
            default:                       r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/i2c_sda_sync.sv
module i2c_sda_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_step_lines.sv
module i2c_step_lines
    import i2c_seq_pkg::*;
(
    input  op_e        op,
    input  logic [1:0] phase,
    input  logic [3:0] bitn,
    input  logic       dbit,
    output logic       scl,
    output logic       sda
);
    always_comb begin
        scl = 1'b1;
        sda = 1'b1;
        case (op)
            OP_START: begin
                scl = (phase != 2'd2);
                sda = (phase == 2'd0);
            end
            OP_RSTART: begin
                scl = (phase == 2'd1) || (phase == 2'd2);
                sda = (phase == 2'd0) || (phase == 2'd1);
            end
            OP_STOP: begin
                scl = (phase != 2'd0);
                sda = (phase == 2'd2);
            end
            OP_WRITE: begin
                scl = (phase == 2'd1);
                sda = (bitn == 4'(BYTE_BITS)) ? 1'b1 : dbit;
            end
            OP_READ: begin
                scl = (phase == 2'd1);
                sda = 1'b1;
            end
            OP_SENDBIT: begin
                scl = (phase == 2'd1);
                sda = dbit;
            end
            default: begin
                scl = 1'b1;
                sda = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int unsigned TICKS_STD  = 10,
    parameter int unsigned TICKS_FAST = 3,
    parameter int unsigned TICKS_FP   = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_wdata,
    input  logic [1:0] cmd_speed,
    output logic [7:0] rsp_rdata,
    output logic       rsp_ackbit,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    localparam int unsigned CW = $clog2(TICKS_STD + 1);

    typedef struct packed {
        logic                 busy;
        op_e                  op;
        logic [1:0]           phase;
        logic [3:0]           bitn;
        logic [CW-1:0]        ticks;
        logic [BYTE_BITS-1:0] sh;
        logic                 scl;
        logic                 sda;
        logic [BYTE_BITS-1:0] rdata;
        logic                 ackbit;
    } state_t;

    state_t st_d, st_q;

    logic          sda_s;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;

    logic                 accept, advance, last_step;
    pos_t                 pos_nxt;
    logic [BYTE_BITS-1:0] sh_nxt, sh_init;
    logic [CW-1:0]        ticks_sel;
    op_e                  nx_op;
    logic [1:0]           nx_phase;
    logic [3:0]           nx_bitn;
    logic                 nx_dbit;
    logic                 nx_scl, nx_sda;

    function automatic logic [CW-1:0] ticks_of(input logic [1:0] spd);
        logic [CW-1:0] t;
        case (spd)
            2'd0:    t = CW'(TICKS_STD);
            2'd1:    t = CW'(TICKS_FAST);
            default: t = CW'(TICKS_FP);
        endcase
        return t;
    endfunction

    i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sda_in),
        .dout  (sda_s)
    );

    i2c_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    i2c_step_lines u_lines (
        .op    (nx_op),
        .phase (nx_phase),
        .bitn  (nx_bitn),
        .dbit  (nx_dbit),
        .scl   (nx_scl),
        .sda   (nx_sda)
    );

    // Step bookkeeping and the inputs of the line decoder for the coming step.
    always_comb begin
        accept    = !st_q.busy && cmd_valid && op_legal(cmd_op);
        advance   = st_q.busy && tmr_expired;
        last_step = step_is_last(st_q.op, st_q.phase, st_q.bitn);
        pos_nxt   = step_next(st_q.op, st_q.phase, st_q.bitn);
        ticks_sel = ticks_of(cmd_speed);

        sh_nxt = st_q.sh;
        if (st_q.op == OP_WRITE && st_q.phase == 2'd2 && st_q.bitn < 4'(BYTE_BITS)) begin
            sh_nxt = {st_q.sh[BYTE_BITS-2:0], 1'b0};
        end else if (st_q.op == OP_READ && st_q.phase == 2'd1) begin
            sh_nxt = {st_q.sh[BYTE_BITS-2:0], sda_s};
        end

        case (cmd_op)
            3'd3:    sh_init = cmd_wdata;
            3'd5:    sh_init = {cmd_wdata[0], {(BYTE_BITS-1){1'b0}}};
            default: sh_init = '0;
        endcase

        if (accept) begin
            nx_op    = op_e'(cmd_op);
            nx_phase = 2'd0;
            nx_bitn  = 4'd0;
            nx_dbit  = sh_init[BYTE_BITS-1];
        end else begin
            nx_op    = st_q.op;
            nx_phase = pos_nxt.phase;
            nx_bitn  = pos_nxt.bitn;
            nx_dbit  = sh_nxt[BYTE_BITS-1];
        end
    end

    // Next-state process.
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.op    = op_e'(cmd_op);
            st_d.phase = 2'd0;
            st_d.bitn  = 4'd0;
            st_d.sh    = sh_init;
            st_d.ticks = ticks_sel;
            st_d.scl   = nx_scl;
            st_d.sda   = nx_sda;
            tmr_load   = 1'b1;
            tmr_val    = ticks_sel - 1'b1;
        end else if (advance) begin
            st_d.sh = sh_nxt;
            if (st_q.op == OP_WRITE && st_q.bitn == 4'(BYTE_BITS) && st_q.phase == 2'd1) begin
                st_d.ackbit = sda_s;
            end
            if (last_step) begin
                st_d.busy = 1'b0;
                if (st_q.op == OP_READ) begin
                    st_d.rdata = sh_nxt;
                end
            end else begin
                st_d.phase = pos_nxt.phase;
                st_d.bitn  = pos_nxt.bitn;
                st_d.scl   = nx_scl;
                st_d.sda   = nx_sda;
                tmr_load   = 1'b1;
                tmr_val    = st_q.ticks - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.op     <= OP_START;
            st_q.phase  <= 2'd0;
            st_q.bitn   <= 4'd0;
            st_q.ticks  <= '0;
            st_q.sh     <= '0;
            st_q.scl    <= 1'b1;
            st_q.sda    <= 1'b1;
            st_q.rdata  <= '0;
            st_q.ackbit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready  = !st_q.busy;
    assign rsp_rdata  = st_q.rdata;
    assign rsp_ackbit = st_q.ackbit;
    assign scl_oe     = !st_q.scl;
    assign sda_oe     = !st_q.sda;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && op_legal(cmd_op)) |=> !cmd_ready); // R1

    AST_HOLD_UNTIL_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !tmr_expired) |=> ($stable(scl_oe) && $stable(sda_oe))); // R1

    AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && !(cmd_valid && op_legal(cmd_op))) |=> ($stable(scl_oe) && $stable(sda_oe))); // R9

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && is_data_op(st_q.op) && !scl_oe) |=> (scl_oe || $stable(sda_oe))); // R6

    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_WRITE && st_q.bitn == 4'(BYTE_BITS)) |-> !sda_oe); // R6

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_READ) |-> !sda_oe); // R7

endmodule

// File: tb/i2c_bit_sequencer_tb.sv
`timescale 1ns/1ps
module i2c_bit_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic [1:0] cmd_speed = 2'd0;
    logic       sda_in = 1'b1;
    logic       cmd_ready;
    logic [7:0] rsp_rdata;
    logic       rsp_ackbit;
    logic       scl_oe, sda_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    i2c_bit_sequencer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_wdata  (cmd_wdata),
        .cmd_speed  (cmd_speed),
        .rsp_rdata  (rsp_rdata),
        .rsp_ackbit (rsp_ackbit),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .sda_in     (sda_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic int ticks_of(input logic [1:0] spd);
        return (spd == 2'd0) ? 10 : (spd == 2'd1) ? 3 : 1;
    endfunction

    function automatic int steps_of(input logic [2:0] op);
        case (op)
            3'd0: return 3;
            3'd1: return 4;
            3'd2: return 3;
            3'd3: return 27;
            3'd4: return 17;
            3'd5: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Expected {SCL,SDA} line levels of step k.
    function automatic logic [1:0] exp_line(input logic [2:0] op, input int k,
                                            input logic [7:0] wd);
        case (op)
            3'd0: return (k == 0) ? 2'b11 : (k == 1) ? 2'b10 : 2'b00;
            3'd1: return (k == 0) ? 2'b01 : (k == 1) ? 2'b11 : (k == 2) ? 2'b10 : 2'b00;
            3'd2: return (k == 0) ? 2'b00 : (k == 1) ? 2'b10 : 2'b11;
            3'd3: begin
                if (k < 24) return {((k % 3) == 1), wd[7 - k / 3]};
                return {((k - 24) == 1), 1'b1};
            end
            3'd4: return (k == 0) ? 2'b01 : {((k % 2) == 1), 1'b1};
            3'd5: return {(k == 1), wd[0]};
            default: return 2'b11;
        endcase
    endfunction

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] wd,
                           input logic [1:0] spd, input logic ackv,
                           input logic [7:0] rbyte_in);
        logic [7:0] rbyte;
        logic [7:0] prev_rdata;
        logic       prev_ack;
        logic [1:0] prev_lines, act;
        int n, s, mism, first_k, ready_bad;
        logic [1:0] first_act, first_exp;
        string req;
        req = req_of(op);
        rbyte = rbyte_in;
        n = ticks_of(spd);
        s = steps_of(op);
        if (op == 3'd4 && n == 1) rbyte = {8{rbyte_in[7]}};
        @(negedge clk);
        prev_rdata = rsp_rdata;
        prev_ack   = rsp_ackbit;
        prev_lines = {!scl_oe, !sda_oe};
        check(cmd_ready == 1'b1, req, "ready before issue", cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_wdata = wd;
        cmd_speed = spd;
        sda_in    = (op == 3'd4) ? rbyte[7] : ackv;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'($urandom);
        cmd_wdata = 8'($urandom);   // R10: disturb inputs while running
        cmd_speed = 2'($urandom);
        if (s == 0) begin
            check(cmd_ready == 1'b1, "R9", "ready after ignored code", cmd_ready, 1);
            check({!scl_oe, !sda_oe} == prev_lines, "R9", "lines after ignored code",
                  {!scl_oe, !sda_oe}, prev_lines);
            check(rsp_rdata == prev_rdata && rsp_ackbit == prev_ack, "R9",
                  "responses after ignored code", {rsp_rdata, rsp_ackbit},
                  {prev_rdata, prev_ack});
            return;
        end
        mism = 0; first_k = -1; ready_bad = 0;
        first_act = 2'b00; first_exp = 2'b00;
        for (int i = 0; i < s * n; i++) begin
            if (i > 0) @(negedge clk);
            if (cmd_ready) ready_bad++;
            if ((i % n) == 0) begin
                int k;
                k = i / n;
                act = {!scl_oe, !sda_oe};
                if (act != exp_line(op, k, wd)) begin
                    if (first_k < 0) begin
                        first_k = k; first_act = act; first_exp = exp_line(op, k, wd);
                    end
                    mism++;
                end
                if (op == 3'd4 && n > 1 && k >= 2 && (k % 2) == 0 && k < 16)
                    sda_in = rbyte[7 - k / 2];
            end
        end
        @(negedge clk);
        check(ready_bad == 0, "R1", "ready during command (cycles high)", ready_bad, 0);
        check(cmd_ready == 1'b1, "R1", "ready after S*N cycles", cmd_ready, 1);
        if (mism != 0)
            $display("  step %0d of op %0d mismatched", first_k, op);
        check(mism == 0, req, "line step trace", first_act, first_exp);
        case (op)
            3'd3: begin
                check(rsp_ackbit == ackv, "R6", "sampled ack", rsp_ackbit, ackv);
                check(rsp_rdata == prev_rdata, "R6", "rdata kept", rsp_rdata, prev_rdata);
            end
            3'd4: begin
                check(rsp_rdata == rbyte, "R7", "received byte", rsp_rdata, rbyte);
                check(rsp_ackbit == prev_ack, "R7", "ackbit kept", rsp_ackbit, prev_ack);
            end
            default: begin
                check(rsp_rdata == prev_rdata && rsp_ackbit == prev_ack, req,
                      "responses kept", {rsp_rdata, rsp_ackbit}, {prev_rdata, prev_ack});
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        void'($urandom(32'd20260115));
        repeat (3) @(negedge clk);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R2", "lines in reset", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R2", "lines released", {scl_oe, sda_oe}, 0);
        check(cmd_ready == 1'b1, "R2", "ready after reset", cmd_ready, 1);
        check(rsp_rdata == 8'h00, "R2", "rdata after reset", rsp_rdata, 0);
        check(rsp_ackbit == 1'b1, "R2", "ackbit after reset", rsp_ackbit, 1);

        run_cmd(3'd0, 8'h00, 2'd0, 1'b1, 8'h00);   // R3 start, standard
        run_cmd(3'd3, 8'hA5, 2'd0, 1'b0, 8'h00);   // R6 write, ack
        run_cmd(3'd3, 8'h3C, 2'd1, 1'b1, 8'h00);   // R6 write, no ack, fast
        run_cmd(3'd4, 8'h00, 2'd1, 1'b1, 8'hC3);   // R7 read, fast
        run_cmd(3'd5, 8'hFE, 2'd1, 1'b1, 8'h00);   // R8 send ack 0
        run_cmd(3'd1, 8'h00, 2'd2, 1'b1, 8'h00);   // R4 repeated start, fast-plus
        run_cmd(3'd3, 8'hFF, 2'd3, 1'b0, 8'h00);   // R6 all ones, fast-plus
        run_cmd(3'd4, 8'h00, 2'd2, 1'b1, 8'h00);   // R7 constant byte, fast-plus
        run_cmd(3'd5, 8'h01, 2'd0, 1'b1, 8'h00);   // R8 send nack
        run_cmd(3'd6, 8'h55, 2'd0, 1'b1, 8'h00);   // R9 ignored code
        run_cmd(3'd7, 8'hAA, 2'd2, 1'b1, 8'h00);   // R9 ignored code
        run_cmd(3'd4, 8'h00, 2'd0, 1'b1, 8'h5A);   // R7 read, standard
        run_cmd(3'd2, 8'h00, 2'd0, 1'b1, 8'h00);   // R5 stop

        for (int j = 0; j < 40; j++) begin
            run_cmd(3'($urandom), 8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom));
        end
        report();
    end

endmodule